// File: doc/BRIEF.md
# DRAM ECC error logger

This block sits beside the error-correction datapath of a DDR memory path and records what that datapath reports. Strobes for a correctable single-bit error and an uncorrectable multi-bit error each arrive with the failing cache-line address, the channel bit, the ECC syndrome and a request-type code. Three further strobes report a refresh timeout, a lock error outside DRAM and a thermal sensor trip. Each event sets a sticky status bit. The first memory error seen is captured into address, syndrome and request-type registers.

An uncorrectable error displaces logged correctable information. A later correctable error never displaces a held log. Software clears status bits by writing ones to them. Reporting is split across three level outputs: a system-error line, a management-interrupt line and a configuration-interrupt line. Each output has its own enable mask. Software is expected to route any one error class to only one of the three outputs. All state is reached through a small word-addressed register port with a combinational read.

Register map (word index on `reg_addr`): 0 status, 1 fault address low word, 2 fault address high word, 3 syndrome, 4 request type, 5 system-error enable, 6 management-interrupt enable, 7 configuration-interrupt enable.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every register reads zero and all three outputs are low.
- R2: Status bit 0 is set by `ce_strb`, bit 1 by `ue_strb`, bit 8 by `rfto_strb`, bit 9 by `lock_strb` and bit 11 by `therm_strb`. All other status bits read zero.
- R3: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an event and the clearing write hit the same bit in the same cycle, the bit stays set.
- R4: The address low word holds the line address (`err_line` bits 24:0) in bits 31:7, reads zero in bits 6:1 and holds the channel in bit 0. The high word holds `err_line` bit 25 in bit 0 and reads zero elsewhere.
- R5: A correctable error that arrives with both error status bits clear loads the address, channel, 8-bit syndrome and 3-bit request type. The request-type register reads zero above bit 2, and code 0 means a processor memory read.
- R6: A correctable error that arrives while the correctable or uncorrectable status bit is set leaves the log unchanged.
- R7: An uncorrectable error that arrives while the uncorrectable status bit is clear replaces the log, even when correctable information is held. While that bit is set, later errors leave the log unchanged.
- R8: The system-error enable keeps bits 0, 1, 8, 9 and 11 of a write. The other two enables keep only bits 1:0. All other enable bits read zero.
- R9: Each output is high exactly when some status bit and the same bit of that output's enable are both set. The output changes in the same cycle as the status it reflects.
- R10: When correctable and uncorrectable strobes arrive together, both status bits set and the log holds the strobed information as an uncorrectable capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_strb | input | 1 | Correctable error event |
| ue_strb | input | 1 | Uncorrectable error event |
| err_line | input | 26 | Failing cache-line address (byte address bits 32:7) |
| err_chan | input | 1 | Failing channel |
| err_syn | input | 8 | ECC syndrome |
| err_dest | input | 3 | Request type of the failing access |
| rfto_strb | input | 1 | Refresh timeout event |
| lock_strb | input | 1 | Lock error outside DRAM |
| therm_strb | input | 1 | Thermal sensor event |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| serr_o | output | 1 | System-error output |
| smi_o | output | 1 | Management-interrupt output |
| sci_o | output | 1 | Configuration-interrupt output |

## Verification
Every strobe and every write is sampled at one rising edge. The status bits, the captured log and the enable registers all show their new value right after that edge. The three outputs and the read data are combinational from those registers, so every result is due one edge after its stimulus. The bench drives each stimulus at a falling edge and lets exactly one rising edge pass. In the low half of the next cycle it walks all eight read addresses and the three outputs, so every observation sits a full edge after its cause and before the next.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
  parameter int ADDR_W    = 33;
  parameter int LINE_LSB  = 7;
  parameter int SYN_W     = 8;
  parameter int DEST_W    = 3;
  parameter int STAT_W    = 16;
  parameter int DATA_W    = 32;
  parameter int RA_W      = 3;
  parameter int N_PATH    = 3;

  localparam int LINE_W   = ADDR_W - LINE_LSB;

  localparam int B_CE     = 0;
  localparam int B_UE     = 1;
  localparam int B_RFTO   = 8;
  localparam int B_LOCK   = 9;
  localparam int B_THERM  = 11;

  localparam logic [STAT_W-1:0] STAT_MASK =
    STAT_W'((1 << B_CE) | (1 << B_UE) | (1 << B_RFTO) | (1 << B_LOCK) | (1 << B_THERM));
  localparam logic [STAT_W-1:0] MEM_MASK =
    STAT_W'((1 << B_CE) | (1 << B_UE));

  typedef enum logic [RA_W-1:0] {
    RA_STAT  = 3'd0,
    RA_ALO   = 3'd1,
    RA_AHI   = 3'd2,
    RA_SYN   = 3'd3,
    RA_DEST  = 3'd4,
    RA_EN_SE = 3'd5,
    RA_EN_MI = 3'd6,
    RA_EN_CI = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic              chan;
    logic [SYN_W-1:0]  syn;
    logic [DEST_W-1:0] dest;
  } err_info_t;

  // Low word: line address above LINE_LSB, channel in bit 0, zeros between.
  function automatic logic [DATA_W-1:0] fmt_addr_lo(input logic [LINE_W-1:0] line,
                                                    input logic chan);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = chan;
    for (int i = LINE_LSB; i < DATA_W; i++) w[i] = line[i-LINE_LSB];
    return w;
  endfunction

  // High word: address bits at and above DATA_W, right-aligned.
  function automatic logic [DATA_W-1:0] fmt_addr_hi(input logic [LINE_W-1:0] line);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = DATA_W; i < ADDR_W; i++) w[i-DATA_W] = line[i-LINE_LSB];
    return w;
  endfunction

  // Level request: any status bit whose enable bit is set.
  function automatic logic req_level(input logic [STAT_W-1:0] st,
                                     input logic [STAT_W-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/ecl_status.sv
module ecl_status
  import ecl_pkg::*;
#(
  parameter logic [STAT_W-1:0] IMPL = STAT_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] status_q
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_impl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          status_q[b] <= 1'b0;
        else if (set_vec[b]) status_q[b] <= 1'b1;
        else if (clr_vec[b]) status_q[b] <= 1'b0;
      end
    end else begin : g_rsvd
      assign status_q[b] = 1'b0;
    end
  end
endmodule

// File: rtl/ecl_capture.sv
module ecl_capture
  import ecl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_strb,
  input  logic      ue_strb,
  input  logic      st_ce,
  input  logic      st_ue,
  input  err_info_t info,
  output err_info_t log_q,
  output logic      ce_load,
  output logic      ue_load
);
  // An uncorrectable error takes the log unless one is already held.
  // A correctable error takes it only when nothing is held.
  always_comb begin
    ue_load = ue_strb && !st_ue;
    ce_load = ce_strb && !ue_strb && !st_ce && !st_ue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   log_q <= '0;
    else if (ue_load || ce_load)  log_q <= info;
  end
endmodule

// File: rtl/ecl_regfile.sv
module ecl_regfile
  import ecl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  input  logic [STAT_W-1:0] status_q,
  input  err_info_t         log_q,
  output logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] en_q [N_PATH],
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [STAT_W-1:0] EN_MASK [N_PATH] = '{STAT_MASK, MEM_MASK, MEM_MASK};
  localparam logic [RA_W-1:0]   EN_BASE = RA_EN_SE;

  assign clr_vec = (reg_wr && reg_addr == RA_STAT) ? (reg_wdata & STAT_MASK) : '0;

  for (genvar p = 0; p < N_PATH; p++) begin : g_en
    localparam logic [RA_W-1:0] MY_RA = EN_BASE + RA_W'(p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          en_q[p] <= '0;
      else if (reg_wr && reg_addr == MY_RA) en_q[p] <= reg_wdata & EN_MASK[p];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx_e'(reg_addr))
      RA_STAT:  reg_rdata = DATA_W'(status_q);
      RA_ALO:   reg_rdata = fmt_addr_lo(log_q.line, log_q.chan);
      RA_AHI:   reg_rdata = fmt_addr_hi(log_q.line);
      RA_SYN:   reg_rdata = DATA_W'(log_q.syn);
      RA_DEST:  reg_rdata = DATA_W'(log_q.dest);
      RA_EN_SE: reg_rdata = DATA_W'(en_q[0]);
      RA_EN_MI: reg_rdata = DATA_W'(en_q[1]);
      RA_EN_CI: reg_rdata = DATA_W'(en_q[2]);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecl_signal.sv
module ecl_signal
  import ecl_pkg::*;
(
  input  logic [STAT_W-1:0] status_q,
  input  logic [STAT_W-1:0] en_q [N_PATH],
  output logic [N_PATH-1:0] req
);
  for (genvar p = 0; p < N_PATH; p++) begin : g_path
    assign req[p] = req_level(status_q, en_q[p]);
  end
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_strb,
  input  logic                ue_strb,
  input  logic [LINE_W-1:0]   err_line,
  input  logic                err_chan,
  input  logic [SYN_W-1:0]    err_syn,
  input  logic [DEST_W-1:0]   err_dest,
  input  logic                rfto_strb,
  input  logic                lock_strb,
  input  logic                therm_strb,
  input  logic [RA_W-1:0]     reg_addr,
  input  logic                reg_wr,
  input  logic [STAT_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                serr_o,
  output logic                smi_o,
  output logic                sci_o
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] en_q [N_PATH];
  logic [N_PATH-1:0] req;
  err_info_t         info;
  err_info_t         log_q;
  logic              ce_load;
  logic              ue_load;

  always_comb begin
    set_vec          = '0;
    set_vec[B_CE]    = ce_strb;
    set_vec[B_UE]    = ue_strb;
    set_vec[B_RFTO]  = rfto_strb;
    set_vec[B_LOCK]  = lock_strb;
    set_vec[B_THERM] = therm_strb;
  end

  assign info = '{line: err_line, chan: err_chan, syn: err_syn, dest: err_dest};

  ecl_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .status_q (status_q)
  );

  ecl_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_strb (ce_strb),
    .ue_strb (ue_strb),
    .st_ce   (status_q[B_CE]),
    .st_ue   (status_q[B_UE]),
    .info    (info),
    .log_q   (log_q),
    .ce_load (ce_load),
    .ue_load (ue_load)
  );

  ecl_regfile u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .status_q  (status_q),
    .log_q     (log_q),
    .clr_vec   (clr_vec),
    .en_q      (en_q),
    .reg_rdata (reg_rdata)
  );

  ecl_signal u_signal (
    .status_q (status_q),
    .en_q     (en_q),
    .req      (req)
  );

  assign serr_o = req[0];
  assign smi_o  = req[1];
  assign sci_o  = req[2];
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker
  import ecl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_strb,
  input logic              ue_strb,
  input logic              lock_strb,
  input logic [SYN_W-1:0]  err_syn,
  input logic [DEST_W-1:0] err_dest,
  input logic [RA_W-1:0]   reg_addr,
  input logic              reg_wr,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [STAT_W-1:0] status_q,
  input logic [SYN_W-1:0]  log_syn,
  input logic [DEST_W-1:0] log_dest,
  input logic              ce_load,
  input logic              ue_load,
  input logic              serr_o,
  input logic              smi_o,
  input logic              sci_o
);
  AST_RSVD_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> ((reg_rdata & ~DATA_W'(STAT_MASK)) == '0)); // R2

  AST_CE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_strb |=> status_q[B_CE]); // R3

  AST_UE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ue_strb |=> status_q[B_UE]); // R10

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[B_LOCK] && !lock_strb) |=> !status_q[B_LOCK]); // R3

  AST_CE_KEEPS_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q[B_CE] || status_q[B_UE]) && !ue_strb) |=> $stable(log_syn) && $stable(log_dest)); // R6

  AST_UE_TAKES_LOG: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_strb && !status_q[B_UE]) |=> (log_syn == $past(err_syn)) && (log_dest == $past(err_dest))); // R7

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ce_load, ue_load})); // R10

  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> !(serr_o || smi_o || sci_o)); // R9
endmodule

bind ecc_err_logger ecl_checker u_ecl_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_strb   (ce_strb),
  .ue_strb   (ue_strb),
  .lock_strb (lock_strb),
  .err_syn   (err_syn),
  .err_dest  (err_dest),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .status_q  (status_q),
  .log_syn   (log_q.syn),
  .log_dest  (log_q.dest),
  .ce_load   (ce_load),
  .ue_load   (ue_load),
  .serr_o    (serr_o),
  .smi_o     (smi_o),
  .sci_o     (sci_o)
);

// File: tb/ecc_err_logger_bench.sv
module ecc_err_logger_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_strb = 0, ue_strb = 0, rfto_strb = 0, lock_strb = 0, therm_strb = 0;
  logic [25:0] err_line = '0;
  logic        err_chan = 0;
  logic [7:0]  err_syn = '0;
  logic [2:0]  err_dest = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr_o, smi_o, sci_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_st;
  logic [25:0] m_line;
  logic        m_chan;
  logic [7:0]  m_syn;
  logic [2:0]  m_dest;
  logic [15:0] m_en [3];

  always #10 clk = ~clk;

  ecc_err_logger u_ecc_err_logger (
    .clk(clk), .rst_n(rst_n), .ce_strb(ce_strb), .ue_strb(ue_strb),
    .err_line(err_line), .err_chan(err_chan), .err_syn(err_syn), .err_dest(err_dest),
    .rfto_strb(rfto_strb), .lock_strb(lock_strb), .therm_strb(therm_strb),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .serr_o(serr_o), .smi_o(smi_o), .sci_o(sci_o));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int k);
    return (32'(k) * 32'h9E37_79B1) ^ (32'(k) << 13) ^ 32'h5A5A_1234;
  endfunction

  // One clock: events (ev[0]=CE ev[1]=UE ev[2]=refresh ev[3]=lock ev[4]=thermal), optional write.
  task automatic step(input logic [4:0] ev, input logic [31:0] d, input logic wr,
                      input logic [2:0] wa, input logic [15:0] wd);
    logic [15:0] setv, clrv;
    @(negedge clk);
    {therm_strb, lock_strb, rfto_strb, ue_strb, ce_strb} = ev;
    err_line = d[25:0]; err_chan = d[26]; err_syn = d[31:24] ^ d[7:0]; err_dest = d[29:27];
    reg_wr = wr; reg_addr = wa; reg_wdata = wd;
    setv = {4'b0, ev[4], 1'b0, ev[3], ev[2], 6'b0, ev[1], ev[0]};
    clrv = (wr && wa == 3'd0) ? (wd & 16'h0B03) : 16'h0;
    if (ev[1] && !m_st[1]) begin
      m_line = err_line; m_chan = err_chan; m_syn = err_syn; m_dest = err_dest;
    end else if (ev[0] && !m_st[0] && !m_st[1]) begin
      m_line = err_line; m_chan = err_chan; m_syn = err_syn; m_dest = err_dest;
    end
    m_st = (m_st & ~clrv) | setv;
    if (wr && wa == 3'd5) m_en[0] = wd & 16'h0B03;
    if (wr && wa == 3'd6) m_en[1] = wd & 16'h0003;
    if (wr && wa == 3'd7) m_en[2] = wd & 16'h0003;
    @(posedge clk);
    #2;
    {therm_strb, lock_strb, rfto_strb, ue_strb, ce_strb} = '0;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic check_all;
    logic [31:0] v;
    @(negedge clk);
    rd(3'd0, v); chk("R2", "status", v, {16'h0, m_st});
    rd(3'd1, v); chk("R4", "addr lo", v, {m_line[24:0], 6'b0, m_chan});
    rd(3'd2, v); chk("R4", "addr hi", v, {31'b0, m_line[25]});
    rd(3'd3, v); chk("R5", "syndrome", v, {24'h0, m_syn});
    rd(3'd4, v); chk("R5", "dest", v, {29'h0, m_dest});
    rd(3'd5, v); chk("R8", "serr en", v, {16'h0, m_en[0]});
    rd(3'd6, v); chk("R8", "smi en", v, {16'h0, m_en[1]});
    rd(3'd7, v); chk("R8", "sci en", v, {16'h0, m_en[2]});
    chk("R9", "serr_o", {31'b0, serr_o}, {31'b0, |(m_st & m_en[0])});
    chk("R9", "smi_o",  {31'b0, smi_o},  {31'b0, |(m_st & m_en[1])});
    chk("R9", "sci_o",  {31'b0, sci_o},  {31'b0, |(m_st & m_en[2])});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep_syn;
    m_st = '0; m_line = '0; m_chan = 0; m_syn = '0; m_dest = '0;
    for (int p = 0; p < 3; p++) m_en[p] = '0;
    repeat (3) @(posedge clk);
    // R1: reset state
    check_all();
    chk("R1", "serr_o at reset", {31'b0, serr_o}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R5 R6 R7 R10: sweep all event combinations, clearing every third step
    for (int i = 0; i < 96; i++) begin
      step(5'(i), mix(i), 1'b0, 3'd0, 16'h0);
      check_all();
      if (i % 3 == 2) begin
        step(5'b0, 32'h0, 1'b1, 3'd0, 16'hFFFF);  // R3 clear all
        check_all();
      end
    end

    // R3: write zero leaves bits set
    step(5'b11111, mix(500), 1'b0, 3'd0, 16'h0);
    step(5'b0, 32'h0, 1'b1, 3'd0, 16'h0000);
    check_all();
    rd(3'd0, v); chk("R3", "write zero keeps status", v, 32'h0B03);
    // R3: same-cycle event and clear, event wins
    step(5'b01000, mix(501), 1'b1, 3'd0, 16'hFFFF);
    check_all();
    rd(3'd0, v); chk("R3", "event beats clear", v, 32'h0200);

    // R6: CE while CE held leaves log
    step(5'b0, 32'h0, 1'b1, 3'd0, 16'hFFFF);
    step(5'b00001, mix(600), 1'b0, 3'd0, 16'h0);
    rd(3'd3, keep_syn);
    step(5'b00001, mix(601), 1'b0, 3'd0, 16'h0);
    check_all();
    rd(3'd3, v); chk("R6", "CE keeps earlier log", v, keep_syn);
    // R7: UE overwrites CE info, then a second UE does not
    step(5'b00010, mix(602), 1'b0, 3'd0, 16'h0);
    check_all();
    rd(3'd1, v); chk("R7", "UE replaces address", v, {m_line[24:0], 6'b0, m_chan});
    rd(3'd3, keep_syn);
    step(5'b00010, mix(603), 1'b0, 3'd0, 16'h0);
    rd(3'd3, v); chk("R7", "second UE keeps log", v, keep_syn);
    // R7: clearing only CE, CE must not displace UE log
    step(5'b0, 32'h0, 1'b1, 3'd0, 16'h0001);
    step(5'b00001, mix(604), 1'b0, 3'd0, 16'h0);
    rd(3'd3, v); chk("R7", "CE under UE keeps log", v, keep_syn);
    // R10: simultaneous CE and UE from empty
    step(5'b0, 32'h0, 1'b1, 3'd0, 16'hFFFF);
    step(5'b00011, mix(605), 1'b0, 3'd0, 16'h0);
    check_all();
    rd(3'd0, v); chk("R10", "both bits", v, 32'h0003);

    // R8 R9: enable sweep over each path against every implemented status class
    for (int p = 0; p < 3; p++) begin
      step(5'b0, 32'h0, 1'b1, 3'(5 + p), 16'hFFFF);
      check_all();
      for (int e = 0; e < 5; e++) begin
        step(5'b0, 32'h0, 1'b1, 3'd0, 16'hFFFF);
        step(5'(1 << e), mix(700 + e), 1'b0, 3'd0, 16'h0);
        check_all();
      end
      step(5'b0, 32'h0, 1'b1, 3'(5 + p), 16'h0000);
      check_all();
    end
    for (int k = 0; k < 32; k++) begin
      step(5'(k), mix(800 + k), 1'b1, 3'(5 + (k % 3)), mix(900 + k)[15:0]);
      check_all();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule